// File: doc/BRIEF.md
# IR Carrier Modulating Transmitter

This block drives an infrared emitter from a queue of symbol records. Each record holds a level (mark or space) and a duration count. Records are written into an eight-entry queue and played back one after another without gaps. A programmable divider turns the reference clock into a transmit tick, and every symbol lasts `count*4 + 3` ticks.

When modulation is on, the burst-carrying symbol is chopped by a carrier with a period of 16 ticks. A 4-bit code `n` sets the carrier high time to `n+1` of those 16 ticks. A polarity bit selects whether marks or spaces carry the bursts. When modulation is off, the output simply follows the record level.

A service request tells the host to refill the queue. It asserts at half empty, or only at empty if the host selects that watermark. The service request has its own interrupt enable. Dropping the enable bit stops transmission at once and empties the queue.

Top module: `ir_burst_tx`

## Requirements
- R1: Tick rate and duration. With divider value `D`, a record with count `c` keeps `busy` high for exactly `(4c+3)*(D+1)` clock cycles.
- R2: Carrier synthesis. During a burst symbol with modulation on, the output is high on ticks whose carrier phase `p` satisfies `p <= n`, where `n` is the duty code. The phase counts ticks modulo 16 and restarts at 0 at the start of every record.
- R3: Burst polarity. With the polarity bit at 0, marks (level 1) carry bursts and spaces do not. With the polarity bit at 1, spaces carry bursts and marks do not. A symbol without a burst drives the output low.
- R4: With modulation off, the output equals the record level for the whole symbol.
- R5: A write record uses bit 16 as the level (1 = mark) and bits [15:0] as the count.
- R6: Records already queued play back to back. `busy` stays high across the record boundary and the total time is the sum of the record durations.
- R7: The queue holds 8 records. A write that arrives while the queue is full and is not drained in the same cycle is dropped.
- R8: When enabled, `svc_req` is high while the queue holds 4 or fewer records if `wm_empty` is 0, and only when it holds 0 records if `wm_empty` is 1. `svc_req` is low while the block is disabled.
- R9: `irq` is high exactly when `svc_req` is high and `irq_en` is 1.
- R10: When no record is playing, `busy` is 0 and `ir_out` is 0, whatever the mode and polarity settings.
- R11: Clearing `tx_en` stops the current symbol and empties the queue within one cycle. Writes made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; low flushes the queue |
| wr_en | input | 1 | Write strobe for one record |
| wr_data | input | 17 | Record: bit 16 level, bits 15:0 count |
| divider | input | 16 | Tick divider; tick every divider+1 clocks |
| duty_code | input | 4 | Carrier high time in ticks minus one |
| mod_en | input | 1 | Modulate bursts onto the carrier |
| pol_inv | input | 1 | Spaces carry bursts instead of marks |
| wm_empty | input | 1 | Service request only when queue is empty |
| irq_en | input | 1 | Interrupt enable for the service request |
| ir_out | output | 1 | Emitter drive |
| busy | output | 1 | A record is being played |
| svc_req | output | 1 | Queue needs refilling |
| irq | output | 1 | Gated service request |

## Verification
The hardest state to reach is a full queue while a symbol is still playing. Reaching it is needed to show that excess writes are dropped. The stimulus first starts a very long record, so nothing drains, and then pushes nine short records behind it. The total busy time then shows exactly eight of them survived. The watermark boundary is reached the same way: a slow divider holds the first record in flight while the queue is filled to four and then to five entries.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
    localparam int CNT_W = 16;
    localparam int REC_W = CNT_W + 1;
    localparam int REM_W = CNT_W + 2;

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } irtx_rec_t;
endpackage

// File: rtl/irtx_tick_gen.sv
module irtx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == div);
        tick = run && !clr && wrap;
        if (!run || clr || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a nonzero divider never yields ticks on consecutive cycles
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/irtx_fifo.sv
module irtx_fifo
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      wr_en,
    input  irtx_rec_t wr_rec,
    input  logic      rd_en,
    output irtx_rec_t rd_rec,
    output logic      empty,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] mem;
        logic [AW-1:0]               wptr;
        logic [AW-1:0]               rptr;
        logic [LW-1:0]               cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        empty  = (st_q.cnt == '0);
        level  = st_q.cnt;
        rd_rec = irtx_rec_t'(st_q.mem[st_q.rptr]);
        do_wr  = wr_en && !flush && (st_q.cnt != LW'(DEPTH));
        do_rd  = rd_en && !flush && !empty;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (do_wr) begin
                st_d.mem[st_q.wptr] = wr_rec;
                st_d.wptr           = bump(st_q.wptr);
            end
            if (do_rd) st_d.rptr = bump(st_q.rptr);
            case ({do_wr, do_rd})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH));
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LW'(DEPTH) && wr_en && !rd_en && !flush) |=> (st_q.cnt == LW'(DEPTH)));
    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            tick,
    input  logic [PH_W-1:0] duty,
    output logic            car_hi
);
    typedef struct packed {
        logic [PH_W-1:0] phase;
    } car_state_t;

    car_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        car_hi = (st_q.phase <= duty);
        if (restart)   st_d.phase = '0;
        else if (tick) st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (st_q.phase == $past(st_q.phase) + 1'b1));
    p_phase_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.phase == '0));
endmodule

// File: rtl/ir_burst_tx.sv
module ir_burst_tx
    import ir_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic [DIV_W-1:0] divider,
    input  logic [3:0]       duty_code,
    input  logic             mod_en,
    input  logic             pol_inv,
    input  logic             wm_empty,
    input  logic             irq_en,
    output logic             ir_out,
    output logic             busy,
    output logic             svc_req,
    output logic             irq
);
    typedef struct packed {
        logic             active;
        logic             lvl;
        logic [REM_W-1:0] remain;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic          tick, car_hi, fifo_empty;
    logic          start_idle, sym_end, pop;
    irtx_rec_t     head;
    logic [LW-1:0] fifo_lvl;

    irtx_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .clr(start_idle),
        .div(divider), .tick(tick)
    );

    irtx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(!tx_en), .wr_en(wr_en),
        .wr_rec(irtx_rec_t'(wr_data)), .rd_en(pop), .rd_rec(head),
        .empty(fifo_empty), .level(fifo_lvl)
    );

    irtx_carrier #(.PH_W(4)) car_i (
        .clk(clk), .rst_n(rst_n), .restart(pop || !tx_en), .tick(tick),
        .duty(duty_code), .car_hi(car_hi)
    );

    always_comb begin
        st_d       = st_q;
        start_idle = tx_en && !st_q.active && !fifo_empty;
        sym_end    = st_q.active && tick && (st_q.remain == '0);
        pop        = start_idle || (sym_end && !fifo_empty);
        if (!tx_en) begin
            st_d.active = 1'b0;
            st_d.remain = '0;
        end else if (pop) begin
            st_d.active = 1'b1;
            st_d.lvl    = head.lvl;
            st_d.remain = {head.cnt, 2'b10};
        end else if (sym_end) begin
            st_d.active = 1'b0;
        end else if (st_q.active && tick) begin
            st_d.remain = st_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        busy = st_q.active;
        if (!st_q.active)  ir_out = 1'b0;
        else if (mod_en)   ir_out = (st_q.lvl ^ pol_inv) && car_hi;
        else               ir_out = st_q.lvl;
        if (!tx_en)        svc_req = 1'b0;
        else if (wm_empty) svc_req = (fifo_lvl == '0);
        else               svc_req = (fifo_lvl <= LW'(DEPTH / 2));
        irq = svc_req && irq_en;
    end

    p_len_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && tx_en && tick && st_q.remain != '0) |=> st_q.active);
    p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> car_hi);
    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_end && !fifo_empty && tx_en) |=> st_q.active);
    p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ir_out);
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!busy && fifo_lvl == '0));
endmodule

// File: tb/ir_burst_tx_tb_top.sv
module ir_burst_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, wr_en = 1'b0, mod_en = 1'b0, pol_inv = 1'b0;
    logic        wm_empty = 1'b0, irq_en = 1'b0;
    logic [16:0] wr_data = '0;
    logic [15:0] divider = '0;
    logic [3:0]  duty_code = '0;
    logic        ir_out, busy, svc_req, irq;

    int n_tests = 0, n_fail = 0;
    int busy_cyc = 0, high_cyc = 0;

    always #2 clk = ~clk;

    ir_burst_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
        .divider(divider), .duty_code(duty_code), .mod_en(mod_en), .pol_inv(pol_inv),
        .wm_empty(wm_empty), .irq_en(irq_en), .ir_out(ir_out), .busy(busy),
        .svc_req(svc_req), .irq(irq)
    );

    always @(negedge clk) begin
        if (busy) busy_cyc <= busy_cyc + 1;
        if (busy && ir_out) high_cyc <= high_cyc + 1;
    end

    // fields: lvl, cnt[16], mod, pol, duty[4], div[8], exp_busy[12], exp_high[12]
    localparam int NV = 10;
    localparam logic [54:0] VEC [NV] = '{
        {1'b1, 16'd3,  1'b0, 1'b0, 4'd0,  8'd0, 12'd15, 12'd15}, // R4 mark
        {1'b0, 16'd3,  1'b0, 1'b0, 4'd0,  8'd0, 12'd15, 12'd0},  // R4 space
        {1'b1, 16'd7,  1'b1, 1'b0, 4'd3,  8'd0, 12'd31, 12'd8},  // R2
        {1'b1, 16'd7,  1'b1, 1'b0, 4'd3,  8'd2, 12'd93, 12'd24}, // R1 R2
        {1'b0, 16'd7,  1'b1, 1'b0, 4'd3,  8'd0, 12'd31, 12'd0},  // R3
        {1'b0, 16'd7,  1'b1, 1'b1, 4'd7,  8'd1, 12'd62, 12'd32}, // R3 inverted
        {1'b1, 16'd5,  1'b1, 1'b1, 4'd7,  8'd0, 12'd23, 12'd0},  // R3 inverted
        {1'b1, 16'd0,  1'b0, 1'b0, 4'd0,  8'd3, 12'd12, 12'd12}, // R1 R5
        {1'b1, 16'd13, 1'b1, 1'b0, 4'd15, 8'd0, 12'd55, 12'd55}, // R2 full duty
        {1'b1, 16'd13, 1'b1, 1'b0, 4'd0,  8'd0, 12'd55, 12'd4}   // R2 min duty
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic lvl, input int cnt);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = {lvl, 16'(cnt)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_counts();
        @(posedge clk);
        #1;
        busy_cyc = 0;
        high_cyc = 0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset busy", busy, 0);
        check("R10 reset ir", ir_out, 0);
        check("R8 svc while disabled", svc_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        irq_en = 1'b1;
        @(negedge clk);
        check("R8 svc empty", svc_req, 1);
        check("R9 irq on", irq, 1);
        irq_en = 1'b0;
        #1;
        check("R9 irq masked", irq, 0);

        for (int v = 0; v < NV; v++) begin
            mod_en    = VEC[v][37];
            pol_inv   = VEC[v][36];
            duty_code = VEC[v][35:32];
            divider   = {8'd0, VEC[v][31:24]};
            clr_counts();
            put(VEC[v][54], int'(VEC[v][53:38]));
            wait_idle();
            check($sformatf("R1 busy vec%0d", v), busy_cyc, int'(VEC[v][23:12]));
            check($sformatf("R2/R3/R4 high vec%0d", v), high_cyc, int'(VEC[v][11:0]));
        end

        // R10: idle output low even when spaces carry bursts
        mod_en = 1'b1; pol_inv = 1'b1; duty_code = 4'd15;
        @(negedge clk);
        check("R10 idle ir", ir_out, 0);
        check("R10 idle busy", busy, 0);

        // R6: back to back
        mod_en = 1'b0; pol_inv = 1'b0; divider = 16'd0;
        clr_counts();
        put(1'b1, 1);
        put(1'b0, 2);
        wait_idle();
        check("R6 chained busy", busy_cyc, 18);
        check("R6 chained high", high_cyc, 7);

        // R7: overflow while a long record plays
        clr_counts();
        put(1'b1, 100);
        for (int k = 0; k < 9; k++) put(1'b0, 0);
        wait_idle();
        check("R7 overflow busy", busy_cyc, 403 + 8 * 3);

        // R8: watermark boundary with a slow divider
        divider = 16'd200;
        for (int k = 0; k < 5; k++) put(1'b1, 100);
        @(negedge clk);
        check("R8 level4 half", svc_req, 1);
        wm_empty = 1'b1;
        #1;
        check("R8 level4 emptymode", svc_req, 0);
        wm_empty = 1'b0;
        put(1'b1, 100);
        @(negedge clk);
        check("R8 level5 half", svc_req, 0);
        check("R1 busy during slow", busy, 1);

        // R11: disable flushes
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check("R11 busy after disable", busy, 0);
        check("R11 ir after disable", ir_out, 0);
        put(1'b1, 3);
        tx_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 no replay", busy, 0);
        check("R11 queue empty", svc_req, 1);
        wm_empty = 1'b1;
        #1;
        check("R11 queue empty strict", svc_req, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule